// File: doc/BRIEF.md
# Return-From-Interrupt State Restore Unit

This unit computes the architectural state that a return-from-interrupt instruction leaves behind. When the instruction completes, the pipeline raises a one-cycle start strobe together with a one-hot variant select. The unit picks the saved return-address and saved-state pair that belongs to that variant and applies that variant's state mask. It then sizes both values according to the 64-bit mode bit found inside the saved state. One cycle later it presents a new program counter and a new state-register value with a write strobe, and it raises a pipeline-flush pulse so that fetch restarts at the new address.

Eight variants are supported. Three are classic returns: the classic return keeps the upper half of the live state, the 64-bit classic return does not, and the hypervisor return uses its own saved pair. Three are embedded returns for critical, debug and machine-check interrupts. The remaining two are an older embedded critical return and a legacy system-call return, which restores from the link and count registers. Privilege checks, exception generation and decode are done elsewhere. The interface has no streaming payload, so it has no valid/ready handshake and no back-pressure. The start strobe is a plain pulse, and the results are pulses that the consumer must capture in the cycle they appear.

Top module: `rfi_restore_unit`

## Requirements
- R1: The one-hot select bit picks the source pair. Bits 0 (classic) and 1 (64-bit classic) use srr_pc/srr_st. Bit 2 (hypervisor) uses hyp_pc/hyp_st, bit 3 (critical) uses crit_pc/crit_st, bit 4 (debug) uses dbg_pc/dbg_st and bit 5 (machine check) uses mck_pc/mck_st. Bit 6 (older critical) uses alt_pc/alt_st, and bit 7 (system-call) uses link_val as the address and count_val as the state.
- R2: The saved state is ANDed with a variant mask. For bits 0, 1 and 2 the mask is ~64'h783F0000. For bits 3, 4 and 5 it is ~64'h3FFF0000. For bit 6 it is ~64'hFFFF0000, and for bit 7 it is 64'h0000FFFF.
- R3: Bits 1:0 of new_pc are always zero on a write.
- R4: When bit 63 of the unmasked saved state is 1, new_pc and the masked state keep all 64 bits.
- R5: When bit 63 of the unmasked saved state is 0, new_pc and the masked state are cut to their low 32 bits, and bits 63:32 become zero.
- R6: For the classic variant (bit 0) with bit 63 of the saved state clear, bits 63:32 of new_state take bits 63:32 of cur_state as sampled with the start strobe.
- R7: new_pc and new_state are updated on the first clock edge after a start cycle. On that same edge state_we and pipe_flush each go high for exactly one cycle.
- R8: A start cycle in which rfi_sel is not exactly one-hot causes no write and no flush, and neither does a select without a start strobe. In those cases new_pc and new_state hold their values.
- R9: During reset, new_pc, new_state, state_we and pipe_flush are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rfi_go | input | 1 | Start strobe, one cycle per return |
| rfi_sel | input | 8 | One-hot variant select |
| srr_pc | input | 64 | Saved address for the classic variants |
| srr_st | input | 64 | Saved state for the classic variants |
| hyp_pc | input | 64 | Saved address for the hypervisor return |
| hyp_st | input | 64 | Saved state for the hypervisor return |
| crit_pc | input | 64 | Saved address for the critical return |
| crit_st | input | 64 | Saved state for the critical return |
| dbg_pc | input | 64 | Saved address for the debug return |
| dbg_st | input | 64 | Saved state for the debug return |
| mck_pc | input | 64 | Saved address for the machine-check return |
| mck_st | input | 64 | Saved state for the machine-check return |
| alt_pc | input | 64 | Saved address for the older critical return |
| alt_st | input | 64 | Saved state for the older critical return |
| link_val | input | 64 | Link register, address for the system-call return |
| count_val | input | 64 | Count register, state for the system-call return |
| cur_state | input | 64 | Live state register |
| new_pc | output | 64 | Restored program counter |
| new_state | output | 64 | Restored state register value |
| state_we | output | 1 | Write strobe for new_pc and new_state |
| pipe_flush | output | 1 | One-cycle pipeline-flush pulse |

## Verification
Every result of this unit is due on the first rising edge after the start cycle. The address, the state, the write strobe and the flush pulse all appear together at that edge, and the strobe and the flush drop again one edge later. The bench drives the inputs on falling edges and samples the outputs on the next falling edge. At that point all four results must be present, and the bench checks again one falling edge after that to confirm the pulses have ended. For the rejected cases, the bench checks that no strobe or flush appears on that same edge and that the restored values are unchanged.

// File: rtl/rfi_pkg.sv
package rfi_pkg;
  localparam int NV = 8;
  localparam int V_CLS = 0;
  localparam int V_C64 = 1;
  localparam int V_HYP = 2;
  localparam int V_CRT = 3;
  localparam int V_DBG = 4;
  localparam int V_MCK = 5;
  localparam int V_OCR = 6;
  localparam int V_SYS = 7;

  function automatic logic [63:0] variant_mask(input int v);
    case (v)
      V_CLS, V_C64, V_HYP:   variant_mask = ~64'h0000_0000_783F_0000;
      V_CRT, V_DBG, V_MCK:   variant_mask = ~64'h0000_0000_3FFF_0000;
      V_OCR:                 variant_mask = ~64'h0000_0000_FFFF_0000;
      default:               variant_mask = 64'h0000_0000_0000_FFFF;
    endcase
  endfunction

  function automatic logic variant_keeps_hi(input int v);
    variant_keeps_hi = (v == V_CLS);
  endfunction
endpackage

// File: rtl/rfi_src_mux.sv
module rfi_src_mux
  import rfi_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [NV-1:0]            sel,
  input  logic [NV-1:0][XLEN-1:0]  pc_bank,
  input  logic [NV-1:0][XLEN-1:0]  st_bank,
  output logic [XLEN-1:0]          pc_o,
  output logic [XLEN-1:0]          st_o,
  output logic [XLEN-1:0]          mask_o,
  output logic                     keep_hi_o
);
  logic [NV-1:0][XLEN-1:0] lane_pc, lane_st, lane_mask;
  logic [NV-1:0]           lane_keep;

  for (genvar g = 0; g < NV; g++) begin : g_lane
    localparam logic [63:0] MASK64 = variant_mask(g);
    localparam logic        KEEP   = variant_keeps_hi(g);
    assign lane_pc[g]   = sel[g] ? pc_bank[g] : '0;
    assign lane_st[g]   = sel[g] ? st_bank[g] : '0;
    assign lane_mask[g] = sel[g] ? MASK64[XLEN-1:0] : '0;
    assign lane_keep[g] = sel[g] & KEEP;
  end

  always_comb begin
    pc_o      = '0;
    st_o      = '0;
    mask_o    = '0;
    for (int i = 0; i < NV; i++) begin
      pc_o   = pc_o | lane_pc[i];
      st_o   = st_o | lane_st[i];
      mask_o = mask_o | lane_mask[i];
    end
    keep_hi_o = |lane_keep;
  end
endmodule

// File: rtl/rfi_width_fix.sv
module rfi_width_fix #(
  parameter int XLEN     = 64,
  parameter int MODE_BIT = XLEN - 1
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] st_i,
  input  logic [XLEN-1:0] mask_i,
  input  logic            keep_hi_i,
  input  logic [XLEN-1:0] cur_i,
  output logic            wide_o,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] st_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] masked;
  logic [HALF-1:0] upper_keep;

  assign wide_o     = st_i[MODE_BIT];
  assign masked     = st_i & mask_i;
  assign upper_keep = keep_hi_i ? cur_i[XLEN-1:HALF] : '0;

  always_comb begin
    if (wide_o) begin
      pc_o = {pc_i[XLEN-1:2], 2'b00};
      st_o = masked;
    end else begin
      pc_o = {{HALF{1'b0}}, pc_i[HALF-1:2], 2'b00};
      st_o = {upper_keep, masked[HALF-1:0]};
    end
  end
endmodule

// File: rtl/rfi_restore_unit.sv
module rfi_restore_unit
  import rfi_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int MODE_BIT = XLEN - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rfi_go,
  input  logic [NV-1:0]   rfi_sel,
  input  logic [XLEN-1:0] srr_pc,
  input  logic [XLEN-1:0] srr_st,
  input  logic [XLEN-1:0] hyp_pc,
  input  logic [XLEN-1:0] hyp_st,
  input  logic [XLEN-1:0] crit_pc,
  input  logic [XLEN-1:0] crit_st,
  input  logic [XLEN-1:0] dbg_pc,
  input  logic [XLEN-1:0] dbg_st,
  input  logic [XLEN-1:0] mck_pc,
  input  logic [XLEN-1:0] mck_st,
  input  logic [XLEN-1:0] alt_pc,
  input  logic [XLEN-1:0] alt_st,
  input  logic [XLEN-1:0] link_val,
  input  logic [XLEN-1:0] count_val,
  input  logic [XLEN-1:0] cur_state,
  output logic [XLEN-1:0] new_pc,
  output logic [XLEN-1:0] new_state,
  output logic            state_we,
  output logic            pipe_flush
);
  localparam int HALF = XLEN / 2;

  logic [NV-1:0][XLEN-1:0] pc_bank, st_bank;
  logic [XLEN-1:0] src_pc, src_st, src_mask, fix_pc, fix_st;
  logic            src_keep, src_wide, sel_onehot, fire;

  always_comb begin
    pc_bank[V_CLS] = srr_pc;   st_bank[V_CLS] = srr_st;
    pc_bank[V_C64] = srr_pc;   st_bank[V_C64] = srr_st;
    pc_bank[V_HYP] = hyp_pc;   st_bank[V_HYP] = hyp_st;
    pc_bank[V_CRT] = crit_pc;  st_bank[V_CRT] = crit_st;
    pc_bank[V_DBG] = dbg_pc;   st_bank[V_DBG] = dbg_st;
    pc_bank[V_MCK] = mck_pc;   st_bank[V_MCK] = mck_st;
    pc_bank[V_OCR] = alt_pc;   st_bank[V_OCR] = alt_st;
    pc_bank[V_SYS] = link_val; st_bank[V_SYS] = count_val;
  end

  assign sel_onehot = (rfi_sel != '0) && ((rfi_sel & (rfi_sel - 1'b1)) == '0);
  assign fire       = rfi_go && sel_onehot;

  rfi_src_mux #(.XLEN(XLEN)) u_mux (
    .sel       (rfi_sel),
    .pc_bank   (pc_bank),
    .st_bank   (st_bank),
    .pc_o      (src_pc),
    .st_o      (src_st),
    .mask_o    (src_mask),
    .keep_hi_o (src_keep)
  );

  rfi_width_fix #(.XLEN(XLEN), .MODE_BIT(MODE_BIT)) u_fix (
    .pc_i      (src_pc),
    .st_i      (src_st),
    .mask_i    (src_mask),
    .keep_hi_i (src_keep),
    .cur_i     (cur_state),
    .wide_o    (src_wide),
    .pc_o      (fix_pc),
    .st_o      (fix_st)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      new_pc     <= '0;
      new_state  <= '0;
      state_we   <= 1'b0;
      pipe_flush <= 1'b0;
    end else begin
      state_we   <= fire;
      pipe_flush <= fire;
      if (fire) begin
        new_pc    <= fix_pc;
        new_state <= fix_st;
      end
    end
  end

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    state_we |-> (new_pc[1:0] == 2'b00)); // R3
  AST_WE_FOLLOWS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (state_we && pipe_flush)); // R7
  AST_NO_SPURIOUS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    state_we |-> $past(rfi_go)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !state_we |-> ($stable(new_pc) && $stable(new_state))); // R8
  AST_NARROW_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !src_wide) |=> (new_pc[XLEN-1:HALF] == '0)); // R5
  AST_KEEP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !src_wide && rfi_sel[V_CLS])
      |=> (new_state[XLEN-1:HALF] == $past(cur_state[XLEN-1:HALF]))); // R6
endmodule

// File: tb/rfi_restore_unit_tb.sv
module rfi_restore_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rfi_go = 1'b0;
  logic [7:0] rfi_sel = '0;
  logic [63:0] srr_pc, srr_st, hyp_pc, hyp_st, crit_pc, crit_st, dbg_pc, dbg_st;
  logic [63:0] mck_pc, mck_st, alt_pc, alt_st, link_val, count_val, cur_state;
  logic [63:0] new_pc, new_state;
  logic state_we, pipe_flush;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rfi_restore_unit dut_i (
    .clk(clk), .rst_n(rst_n), .rfi_go(rfi_go), .rfi_sel(rfi_sel),
    .srr_pc(srr_pc), .srr_st(srr_st), .hyp_pc(hyp_pc), .hyp_st(hyp_st),
    .crit_pc(crit_pc), .crit_st(crit_st), .dbg_pc(dbg_pc), .dbg_st(dbg_st),
    .mck_pc(mck_pc), .mck_st(mck_st), .alt_pc(alt_pc), .alt_st(alt_st),
    .link_val(link_val), .count_val(count_val), .cur_state(cur_state),
    .new_pc(new_pc), .new_state(new_state), .state_we(state_we), .pipe_flush(pipe_flush)
  );

  // {variant, saved pc, saved state, current state}
  localparam int NVEC = 12;
  localparam logic [199:0] VEC [NVEC] = '{
    {8'd0, 64'h1234_5678_9ABC_DEF3, 64'h0123_4567_FFFF_FFFF, 64'hCAFE_F00D_0000_1111},
    {8'd0, 64'h8000_0000_0000_1007, 64'h8000_0001_FFFF_FFFF, 64'hCAFE_F00D_0000_1111},
    {8'd1, 64'h1111_2222_3333_4446, 64'h7FFF_0000_FFFF_FFFF, 64'hABCD_0000_0000_0000},
    {8'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
    {8'd2, 64'h0000_0000_DEAD_BEEF, 64'h0000_FFFF_783F_0001, 64'hFFFF_FFFF_0000_0000},
    {8'd3, 64'hA000_0000_0000_0101, 64'hC000_0000_FFFF_FFFF, 64'h5555_5555_0000_0000},
    {8'd4, 64'h0000_0001_0000_0042, 64'h0000_0000_3FFF_FF00, 64'h7777_7777_0000_0000},
    {8'd5, 64'h8765_4321_0000_0FFE, 64'h8000_0000_C000_0003, 64'h0},
    {8'd6, 64'hF000_0000_1234_5679, 64'h8123_0000_FFFF_ABCD, 64'h0},
    {8'd6, 64'h0000_0000_0000_0002, 64'h0000_1234_FFFF_FFFF, 64'h9999_9999_0000_0000},
    {8'd7, 64'h8000_0000_0000_F00B, 64'h8000_0000_1234_5678, 64'h0},
    {8'd7, 64'h0000_0000_0000_C00D, 64'h0000_0000_ABCD_EF01, 64'h4444_4444_0000_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_mask(input int v);
    if (v <= 2) return ~64'h783F0000;
    if (v <= 5) return ~64'h3FFF0000;
    if (v == 6) return ~64'hFFFF0000;
    return 64'h0000FFFF;
  endfunction

  task automatic fill_pairs();
    srr_pc = 64'hA0A0_0000_0000_1000; srr_st = 64'h0B0B_0000_0000_2000;
    hyp_pc = 64'hA1A1_0000_0000_1100; hyp_st = 64'h1B1B_0000_0000_2100;
    crit_pc = 64'hA2A2_0000_0000_1200; crit_st = 64'h2B2B_0000_0000_2200;
    dbg_pc = 64'hA3A3_0000_0000_1300; dbg_st = 64'h3B3B_0000_0000_2300;
    mck_pc = 64'hA4A4_0000_0000_1400; mck_st = 64'h4B4B_0000_0000_2400;
    alt_pc = 64'hA5A5_0000_0000_1500; alt_st = 64'h5B5B_0000_0000_2500;
    link_val = 64'hA6A6_0000_0000_1600; count_val = 64'h6B6B_0000_0000_2600;
  endtask

  task automatic put_pair(input int v, input logic [63:0] p, input logic [63:0] s);
    case (v)
      0, 1: begin srr_pc = p; srr_st = s; end
      2: begin hyp_pc = p; hyp_st = s; end
      3: begin crit_pc = p; crit_st = s; end
      4: begin dbg_pc = p; dbg_st = s; end
      5: begin mck_pc = p; mck_st = s; end
      6: begin alt_pc = p; alt_st = s; end
      default: begin link_val = p; count_val = s; end
    endcase
  endtask

  initial begin
    fill_pairs();
    cur_state = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 new_pc", new_pc, 64'h0);
    chk("R9 new_state", new_state, 64'h0);
    chk("R9 state_we", {63'h0, state_we}, 64'h0);
    chk("R9 pipe_flush", {63'h0, pipe_flush}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1, R2, R3, R4, R5, R6, R7
    for (int k = 0; k < NVEC; k++) begin
      int v;
      logic [63:0] p, s, c, ep, es;
      v = int'(VEC[k][199:192]);
      p = VEC[k][191:128];
      s = VEC[k][127:64];
      c = VEC[k][63:0];
      ep = p & ~64'h3;
      es = s & model_mask(v);
      if (!s[63]) begin
        ep[63:32] = '0;
        es[63:32] = (v == 0) ? c[63:32] : 32'h0;
      end
      fill_pairs();
      put_pair(v, p, s);
      cur_state = c;
      rfi_sel = 8'b1 << v;
      rfi_go = 1'b1;
      @(negedge clk);
      rfi_go = 1'b0;
      rfi_sel = '0;
      cur_state = 64'hDEAD_DEAD_DEAD_DEAD;
      chk("R7 state_we high", {63'h0, state_we}, 64'h1);
      chk("R7 pipe_flush high", {63'h0, pipe_flush}, 64'h1);
      chk("R1 R3 R4 R5 new_pc", new_pc, ep);
      chk("R2 R4 R5 R6 new_state", new_state, es);
      @(negedge clk);
      chk("R7 state_we one cycle", {63'h0, state_we}, 64'h0);
      chk("R7 pipe_flush one cycle", {63'h0, pipe_flush}, 64'h0);
    end

    // Directed: last written values must hold through rejected starts (R8)
    begin
      logic [63:0] hp, hs;
      hp = new_pc;
      hs = new_state;
      fill_pairs();
      rfi_sel = 8'h00; rfi_go = 1'b1;
      @(negedge clk);
      rfi_go = 1'b0;
      chk("R8 no select state_we", {63'h0, state_we}, 64'h0);
      chk("R8 no select pipe_flush", {63'h0, pipe_flush}, 64'h0);
      rfi_sel = 8'b0001_0100; rfi_go = 1'b1;
      @(negedge clk);
      rfi_go = 1'b0; rfi_sel = '0;
      chk("R8 two selects state_we", {63'h0, state_we}, 64'h0);
      chk("R8 two selects pipe_flush", {63'h0, pipe_flush}, 64'h0);
      chk("R8 two selects pc held", new_pc, hp);
      rfi_sel = 8'b0000_1000; rfi_go = 1'b0;
      @(negedge clk);
      rfi_sel = '0;
      chk("R8 select without go state_we", {63'h0, state_we}, 64'h0);
      chk("R8 select without go pc held", new_pc, hp);
      chk("R8 select without go state held", new_state, hs);
    end

    // Directed: back-to-back starts, second result replaces first (R7)
    fill_pairs();
    rfi_sel = 8'b0000_0100; rfi_go = 1'b1; // hyp: A1A1.. pc, bit63 clear
    @(negedge clk);
    rfi_sel = 8'b0010_0000;                // mck
    chk("R7 back-to-back first pc", new_pc, 64'h0000_0000_0000_1100);
    @(negedge clk);
    rfi_go = 1'b0; rfi_sel = '0;
    chk("R7 back-to-back strobe stays", {63'h0, state_we}, 64'h1);
    chk("R1 back-to-back second pc", new_pc, 64'h0000_0000_0000_1400);
    chk("R2 back-to-back second state", new_state, 64'h0000_0000_0000_2400);

    // Directed: reset clears outputs after activity (R9)
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 reset clears pc", new_pc, 64'h0);
    chk("R9 reset clears state", new_state, 64'h0);
    rst_n = 1'b1;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule